// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host port and an external asynchronous static RAM of 256 four-bit words. The RAM has separate data-in and data-out pins. The host raises a request with a write flag, an address and write data. The sequencer then drives the RAM's address, an active-low chip select, an active-high chip enable, an active-low output enable and an active-low write enable. It steps these strobes through phases whose lengths are whole clock cycles. Each length is derived from a nanosecond limit and a clock-period parameter.

A write has three phases. In the first, the address and data are presented with both selects asserted. In the second, write enable is held low. In the third, all strobes are released and the address and data are held. A read keeps the selects and output enable asserted for the longest access time, then registers the RAM's data-out. Each transaction ends with a one-cycle done pulse. Between transactions the RAM stays in standby.

Top module: `sram_strobe_seq`

## Requirements
- R1: `mem_we_n` is low only while `mem_cs_n` is 0 and `mem_ce` is 1, and `mem_oe_n` is 1 throughout that time.
- R2: `mem_addr` and `mem_din` do not change during any cycle in which `mem_we_n` is low, including the cycle in which it falls.
- R3: Before `mem_we_n` falls, both selects have been active for at least ceil(25 ns / CLK_NS) cycles and the address has been stable for at least ceil(20 ns / CLK_NS) cycles. The low pulse then lasts at least ceil(50 ns / CLK_NS) cycles.
- R4: When `mem_we_n` rises, write data has been stable for at least ceil(30/CLK_NS) cycles, and both selects and the address for at least ceil(80/CLK_NS) cycles. After the rise, the address is held for at least ceil(5/CLK_NS) cycles and the data for at least ceil(10/CLK_NS) cycles.
- R5: A write keeps `busy` high for at least ceil(140/CLK_NS) cycles.
- R6: A read holds `mem_cs_n`=0, `mem_ce`=1, `mem_oe_n`=0 and `mem_we_n`=1 until the address, the selects and the output enable have each been applied for their access time (130, 140 and 70 ns, rounded up to cycles). `rdata` then equals the word stored at that address.
- R7: `done` is high for exactly one cycle at the end of each transaction. After a read, `rdata` is valid while `done` is high.
- R8: During reset and whenever `busy` is 0, `mem_cs_n`=1, `mem_ce`=0, `mem_we_n`=1 and `mem_oe_n`=1.
- R9: A request is taken only at a clock edge where `busy` is 0. A request held high while `busy` is 1 is taken once the sequencer is idle, and is never lost. The latched address does not change while busy.
- R10: Every phase length is ceil(ns/CLK_NS), with a minimum of one cycle. The write-pulse and recovery phases are stretched so that the 80 ns select-to-end and address-to-end limits and the 140 ns cycle minimum hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Transaction request, held until taken |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | DW | Registered read data |
| mem_addr | output | AW | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_ce | output | 1 | RAM chip enable, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_din | output | DW | RAM data-in pins |
| mem_dout | input | DW | RAM data-out pins |

## Verification
The bench builds the block with a 10 ns clock and the default nanosecond limits. This gives a 3-cycle setup phase, a 5-cycle write pulse, a 6-cycle recovery phase and a 14-cycle read access. The pulse length is where the 50 ns pulse width and the 80 ns select-to-end limit meet. The recovery length comes from the 140 ns cycle minimum, not from the 5 ns recovery limit. A read access is set by the 140 ns select access, so every interval sits exactly at its rounded limit. Shortening any phase by one cycle therefore breaks a check in the bench's RAM model. That model returns corrupted data when a read is captured early.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSETUP  = 3'd1,
    ST_WPULSE  = 3'd2,
    ST_WRECOV  = 3'd3,
    ST_RACCESS = 3'd4
  } seq_state_e;

  // round a nanosecond limit up to whole clock cycles
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a - b, floored at zero
  function automatic int unsigned usub(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/seq_interval_timer.sv
module seq_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R10
  timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
  import sram_seq_pkg::*;
#(
  parameter int          CNT_W     = 8,
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned PULSE_CYC = 5,
  parameter int unsigned REC_CYC   = 6,
  parameter int unsigned RACC_CYC  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_wr,
  input  logic             expired,
  output seq_state_e       state_q,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             finish
);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RACC  = CNT_W'(RACC_CYC - 1);

  seq_state_e state_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    finish   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        accept = 1'b1;
        load   = 1'b1;
        if (req_wr) begin state_d = ST_WSETUP;  load_val = LD_SETUP; end
        else        begin state_d = ST_RACCESS; load_val = LD_RACC;  end
      end
      ST_WSETUP: if (expired) begin
        state_d = ST_WPULSE; load = 1'b1; load_val = LD_PULSE;
      end
      ST_WPULSE: if (expired) begin
        state_d = ST_WRECOV; load = 1'b1; load_val = LD_REC;
      end
      ST_WRECOV: if (expired) begin
        state_d = ST_IDLE; finish = 1'b1;
      end
      ST_RACCESS: if (expired) begin
        state_d = ST_IDLE; finish = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R10
  phase_exit_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !expired) |=> (state_q == $past(state_q)));

endmodule

// File: rtl/seq_strobe_decode.sv
module seq_strobe_decode
  import sram_seq_pkg::*;
(
  input  seq_state_e state,
  output logic       cs_n,
  output logic       ce,
  output logic       oe_n,
  output logic       we_n
);

  always_comb begin
    cs_n = 1'b1;
    ce   = 1'b0;
    oe_n = 1'b1;
    we_n = 1'b1;
    unique case (state)
      ST_WSETUP:  begin cs_n = 1'b0; ce = 1'b1; end
      ST_WPULSE:  begin cs_n = 1'b0; ce = 1'b1; we_n = 1'b0; end
      ST_RACCESS: begin cs_n = 1'b0; ce = 1'b1; oe_n = 1'b0; end
      default:    ;
    endcase
  end

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_seq_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          DW          = 4,
  parameter int          CNT_W       = 8,
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned T_SELWL_NS  = 25,
  parameter int unsigned T_ASU_NS    = 20,
  parameter int unsigned T_WP_NS     = 50,
  parameter int unsigned T_DOVL_NS   = 30,
  parameter int unsigned T_SELEND_NS = 80,
  parameter int unsigned T_AVEND_NS  = 80,
  parameter int unsigned T_WREC_NS   = 5,
  parameter int unsigned T_DHOLD_NS  = 10,
  parameter int unsigned T_WCYC_NS   = 140,
  parameter int unsigned T_AACC_NS   = 130,
  parameter int unsigned T_SACC_NS   = 140,
  parameter int unsigned T_OACC_NS   = 70
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_din,
  input  logic [DW-1:0] mem_dout
);

  localparam int unsigned SETUP_CYC = umax(1, umax(ns2cyc(T_SELWL_NS, CLK_NS), ns2cyc(T_ASU_NS, CLK_NS)));
  localparam int unsigned PULSE_CYC = umax(1, umax(umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DOVL_NS, CLK_NS)),
    usub(umax(ns2cyc(T_SELEND_NS, CLK_NS), ns2cyc(T_AVEND_NS, CLK_NS)), SETUP_CYC)));
  localparam int unsigned REC_CYC   = umax(1, umax(umax(ns2cyc(T_WREC_NS, CLK_NS), ns2cyc(T_DHOLD_NS, CLK_NS)),
    usub(ns2cyc(T_WCYC_NS, CLK_NS), SETUP_CYC + PULSE_CYC)));
  localparam int unsigned RACC_CYC  = umax(1, umax(ns2cyc(T_AACC_NS, CLK_NS),
    umax(ns2cyc(T_SACC_NS, CLK_NS), ns2cyc(T_OACC_NS, CLK_NS))));

  seq_state_e       state_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             ev_accept;
  logic             ev_finish;
  logic             ev_read_capture;

  seq_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  seq_ctrl_fsm #(
    .CNT_W     (CNT_W),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .REC_CYC   (REC_CYC),
    .RACC_CYC  (RACC_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_wr   (req_wr),
    .expired  (tmr_expired),
    .state_q  (state_q),
    .load     (tmr_load),
    .load_val (tmr_val),
    .accept   (ev_accept),
    .finish   (ev_finish)
  );

  seq_strobe_decode u_decode (
    .state (state_q),
    .cs_n  (mem_cs_n),
    .ce    (mem_ce),
    .oe_n  (mem_oe_n),
    .we_n  (mem_we_n)
  );

  assign ev_read_capture = ev_finish && (state_q == ST_RACCESS);
  assign busy            = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_din  <= '0;
      rdata    <= '0;
      done     <= 1'b0;
    end else begin
      done <= ev_finish;
      if (ev_accept) begin
        mem_addr <= req_addr;
        mem_din  <= req_wdata;
      end
      if (ev_read_capture) rdata <= mem_dout;
    end
  end

  // R1
  we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_ce && mem_oe_n));

  // R2
  addr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_din)));

  // R8
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && !mem_ce && mem_we_n && mem_oe_n));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem_addr));

endmodule

// File: tb/tb_sram_strobe_seq.sv
module tb_sram_strobe_seq;

  localparam int TB_PERIOD = 10;
  localparam int NV = 12;

  // bench's own rounding: whole quotient plus one if anything is left over
  function automatic int cyc(input int ns);
    return ns / TB_PERIOD + ((ns % TB_PERIOD) != 0 ? 1 : 0);
  endfunction

  // {write, address, data}
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 8'h00, 4'hA}, {1'b0, 8'h00, 4'h0}, {1'b1, 8'hFF, 4'h5}, {1'b0, 8'hFF, 4'h0},
    {1'b0, 8'h3C, 4'h0}, {1'b1, 8'h3C, 4'h0}, {1'b1, 8'h3C, 4'hF}, {1'b0, 8'h3C, 4'h0},
    {1'b1, 8'h81, 4'h6}, {1'b0, 8'h80, 4'h0}, {1'b0, 8'h81, 4'h0}, {1'b0, 8'hFF, 4'h0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req, req_wr;
  logic [7:0] req_addr;
  logic [3:0] req_wdata;
  logic busy, done;
  logic [3:0] rdata;
  logic [7:0] mem_addr;
  logic mem_cs_n, mem_ce, mem_oe_n, mem_we_n;
  logic [3:0] mem_din;
  logic [3:0] mem_dout;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  bit finished = 0;

  logic [3:0] ram   [256];
  logic [3:0] shadow[256];

  always #(TB_PERIOD/2) clk = ~clk;

  sram_strobe_seq #(.CLK_NS(TB_PERIOD)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_din(mem_din), .mem_dout(mem_dout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // RAM model and timing monitor, evaluated between edges
  logic [7:0] p_addr;
  logic [3:0] p_din;
  logic       p_we_n = 1'b1;
  int sel_run = 0, addr_run = 0, din_run = 0, low_run = 0, oe_run = 0, rise_age = 0;

  function automatic int sat(input int v);
    return (v > 1000) ? 1000 : v;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      sel_run = 0; addr_run = 0; din_run = 0; low_run = 0; oe_run = 0; rise_age = 0;
      p_we_n = 1'b1; p_addr = mem_addr; p_din = mem_din;
      mem_dout = 4'h0;
    end else begin
      automatic bit sel_now  = !mem_cs_n && mem_ce;
      automatic bit addr_chg = (mem_addr != p_addr);
      automatic bit din_chg  = (mem_din != p_din);
      automatic bit we_fall  = p_we_n && !mem_we_n;
      automatic bit we_rise  = !p_we_n && mem_we_n;
      if (done) done_cnt++;
      if (!mem_we_n) begin
        chk(sel_now && mem_oe_n, "R1 write window", {mem_cs_n, mem_ce, mem_oe_n}, 3'b011);
        chk(!addr_chg && !din_chg, "R2 addr/data stable while write low",
            {mem_addr, mem_din}, {p_addr, p_din});
      end
      if (we_fall) begin
        chk(sel_run >= cyc(25), "R3 select to write low", sel_run, cyc(25));
        chk(addr_run >= cyc(20), "R3 address setup", addr_run, cyc(20));
      end
      if (we_rise) begin
        chk(low_run >= cyc(50), "R3 write pulse width", low_run, cyc(50));
        chk(din_run >= cyc(30), "R4 data overlap", din_run, cyc(30));
        chk(sel_run >= cyc(80), "R4 select to end of write", sel_run, cyc(80));
        chk(addr_run >= cyc(80), "R4 address to end of write", addr_run, cyc(80));
        ram[p_addr] = p_din;
      end
      if (rise_age > 0 && addr_chg)
        chk(rise_age >= cyc(5), "R4 address recovery", rise_age, cyc(5));
      if (rise_age > 0 && din_chg)
        chk(rise_age >= cyc(10), "R4 data hold", rise_age, cyc(10));
      if (!busy)
        chk(mem_cs_n && !mem_ce && mem_we_n && mem_oe_n, "R8 idle standby",
            {mem_cs_n, mem_ce, mem_we_n, mem_oe_n}, 4'b1011);
      // update runs, each including the current sample
      sel_run  = sel_now ? sat(sel_run + 1) : 0;
      addr_run = addr_chg ? 1 : sat(addr_run + 1);
      din_run  = din_chg ? 1 : sat(din_run + 1);
      low_run  = !mem_we_n ? sat(low_run + 1) : 0;
      oe_run   = (!mem_oe_n && sel_now && mem_we_n) ? sat(oe_run + 1) : 0;
      if (we_fall) rise_age = 0;
      else if (we_rise) rise_age = 1;
      else if (rise_age > 0) rise_age = sat(rise_age + 1);
      // read data is only correct once every access time has elapsed
      if (oe_run >= cyc(70) && sel_run >= cyc(140) && addr_run >= cyc(130))
        mem_dout = ram[mem_addr];
      else
        mem_dout = ~ram[mem_addr];
      p_addr = mem_addr; p_din = mem_din; p_we_n = mem_we_n;
    end
  end

  task automatic run_txn(input logic wr, input logic [7:0] a, input logic [3:0] d,
                         output logic [3:0] rd, output int bcyc);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    while (busy) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    bcyc = 0;
    while (!done) begin
      if (busy) bcyc++;
      @(negedge clk);
    end
    rd = rdata;
    if (wr) shadow[a] = d;
    @(negedge clk);
    chk(!done, "R7 done lasts one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] rd;
    int bc;
    for (int i = 0; i < 256; i++) begin
      ram[i]    = 4'(i) ^ 4'(i >> 4);
      shadow[i] = 4'(i) ^ 4'(i >> 4);
    end
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(mem_cs_n && !mem_ce && mem_we_n && mem_oe_n, "R8 strobes in reset",
        {mem_cs_n, mem_ce, mem_we_n, mem_oe_n}, 4'b1011);
    chk(!busy && !done, "R8 busy/done in reset", {busy, done}, 0);
    rst_n = 1'b1;

    // vector table
    for (int v = 0; v < NV; v++) begin
      automatic logic       wr = VEC[v][12];
      automatic logic [7:0] a  = VEC[v][11:4];
      automatic logic [3:0] d  = VEC[v][3:0];
      automatic logic [3:0] exp_rd = shadow[a];
      run_txn(wr, a, d, rd, bc);
      if (wr) chk(bc >= cyc(140), "R5 write cycle length", bc, cyc(140));
      else begin
        chk(rd == exp_rd, "R6 read data", rd, exp_rd);
        chk(bc >= cyc(140), "R6 read access length", bc, cyc(140));
      end
    end

    // R9: request raised while busy is held off, then served
    begin
      automatic int d0;
      @(negedge clk);
      req = 1'b1; req_wr = 1'b1; req_addr = 8'h5A; req_wdata = 4'h9;
      @(negedge clk);
      chk(busy, "R9 write accepted when idle", busy, 1);
      shadow[8'h5A] = 4'h9;
      d0 = done_cnt;
      run_txn(1'b0, 8'h5A, 4'h0, rd, bc);
      chk(rd == 4'h9, "R9 held-off read sees prior write", rd, 9);
      chk(done_cnt - d0 == 2, "R9 both transactions completed", done_cnt - d0, 2);
    end

    // R10: both address extremes after back-to-back writes
    run_txn(1'b1, 8'hFF, 4'h3, rd, bc);
    run_txn(1'b1, 8'h00, 4'hC, rd, bc);
    run_txn(1'b0, 8'hFF, 4'h0, rd, bc);
    chk(rd == 4'h3, "R10 top address keeps data", rd, 3);
    run_txn(1'b0, 8'h00, 4'h0, rd, bc);
    chk(rd == 4'hC, "R10 bottom address keeps data", rd, 12);

    repeat (3) @(negedge clk);
    chk(!busy && mem_cs_n && !mem_ce, "R8 returns to standby", {busy, mem_cs_n, mem_ce}, 3'b010);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule